// File: doc/BRIEF.md
# Load/Store Effective Address Generator

This block forms the memory address for a load or store and the new value of the base register, given the operands that decode has already gathered: the base register value, the address of the instruction itself, a 12-bit immediate magnitude, a register offset with a shift kind and shift amount, an add/subtract select, an offset-source select, and an addressing mode. Four modes are supported. Plain pre-indexing adds the offset to the base. Pre-indexing with update adds the offset and also returns the sum as the new base. Post-indexing addresses memory at the unmodified base and returns base plus offset as the new base. PC-relative addressing takes the instruction address plus 8 as its anchor and applies the signed immediate.

Requests arrive on a valid/ready stream and results leave on a second valid/ready stream through one register stage. A request is taken on a clock edge where `in_valid` and `in_ready` are both high. Its result is presented on the following cycle and stays unchanged until the consumer takes it with `out_ready`. When the output stage is empty, or is being emptied in the same cycle, `in_ready` is high, so the block sustains one request per cycle when the consumer does not stall. Back-pressure from `out_ready` reaches `in_ready` in the same cycle through combinational logic.

Top module: `agu_ea_gen`

## Requirements
- R1: Mode code 0 (pre-index): the address is anchor plus or minus the offset, where the anchor is `in_base`. The update enable is 0 and the update value equals the address.
- R2: Mode code 1 (pre-index with update): the address is base plus or minus the offset. The update value equals that address and the update enable is 1.
- R3: Mode code 2 (post-index): the address equals `in_base` unchanged. The update value is base plus or minus the offset, and the update enable is always 1.
- R4: Mode code 3 (PC-relative): the address is `in_pc` + 8 plus or minus the 12-bit immediate. The update enable is 0, the update value equals the address, and `in_use_reg` has no effect.
- R5: With `in_use_reg` = 0, the offset is the zero-extended 12-bit immediate, so it ranges from 0 to 4095. With `in_use_reg` = 1 (modes 0 to 2), the offset is the shifted register value. `in_sub` = 1 subtracts the offset and `in_sub` = 0 adds it.
- R6: The register offset is shifted by `in_shamt` (0 to 31) according to `in_shkind`: 0 is logical left, 1 is logical right, 2 is arithmetic right, and 3 applies no shift. A shift amount of 0 leaves the value unchanged for every kind.
- R7: All address sums and differences wrap modulo 2^32.
- R8: A request accepted at a clock edge appears on the output with `out_valid` high after that edge. While `out_valid` is high and `out_ready` is low, the outputs are held unchanged. A taken result with no new request leaves `out_valid` low.
- R9: `in_ready` equals `!out_valid || out_ready`, which allows back-to-back acceptance at one request per cycle.
- R10: During and directly after reset, `out_valid` is 0 and `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request valid |
| in_ready | output | 1 | Request can be accepted |
| in_mode | input | 2 | Addressing mode: 0 pre, 1 pre with update, 2 post, 3 PC-relative |
| in_base | input | 32 | Base register value |
| in_pc | input | 32 | Address of the instruction |
| in_imm | input | 12 | Immediate offset magnitude |
| in_use_reg | input | 1 | Select the register offset instead of the immediate |
| in_sub | input | 1 | Subtract the offset instead of adding it |
| in_roff | input | 32 | Register offset value |
| in_shkind | input | 2 | Shift kind: 0 LSL, 1 LSR, 2 ASR, 3 none |
| in_shamt | input | 5 | Shift amount |
| out_valid | output | 1 | Result valid |
| out_ready | input | 1 | Consumer takes the result |
| out_ea | output | 32 | Effective address |
| out_wb_data | output | 32 | New base register value |
| out_wb_en | output | 1 | Base register update enable |

## Verification
The in-RTL assertions check on every cycle the mode invariants that are independent of the offset value. These are: PC-relative and plain pre-indexing never request an update, post-indexing always addresses at the raw base and always updates, and pre-indexing with update returns the address it used. They also check the output-hold and drain rules of the stream. The arithmetic itself can only be shown by the bench's scenarios, which are compared against an independent model. The scenarios cover each shift kind at amounts of 0 and 31, arithmetic shifts of negative values, subtraction, the immediate limits of 0 and 4095, wrap-around in both directions, and PC-relative offsets. Random traffic under random back-pressure shows that no result is lost, duplicated or reordered.

// File: rtl/agu_pkg.sv
package agu_pkg;

  typedef enum logic [1:0] {
    AM_PRE    = 2'd0,
    AM_PRE_WB = 2'd1,
    AM_POST   = 2'd2,
    AM_PC_REL = 2'd3
  } addr_mode_e;

  typedef enum logic [1:0] {
    SH_LSL  = 2'd0,
    SH_LSR  = 2'd1,
    SH_ASR  = 2'd2,
    SH_NONE = 2'd3
  } shift_kind_e;

endpackage

// File: rtl/agu_offset_shift.sv
module agu_offset_shift
  import agu_pkg::*;
#(
  parameter int unsigned W       = 32,
  parameter int unsigned SHAMT_W = 5
) (
  input  logic [W-1:0]       value,
  input  shift_kind_e        kind,
  input  logic [SHAMT_W-1:0] amount,
  output logic [W-1:0]       shifted
);

  localparam int unsigned STAGES = SHAMT_W;

  logic            go_left;
  logic            fill_bit;
  logic [W-1:0]    stage [STAGES+1];

  assign go_left  = (kind == SH_LSL);
  assign fill_bit = (kind == SH_ASR) ? value[W-1] : 1'b0;
  assign stage[0] = value;

  // log-depth barrel: stage i moves by 2**i when amount bit i is set
  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    localparam int unsigned D = 2 ** i;
    logic [W-1:0] fill_mask;
    logic [W-1:0] moved;

    assign fill_mask = {W{fill_bit}} << (W - D);

    always_comb begin
      if (go_left) moved = stage[i] << D;
      else         moved = (stage[i] >> D) | fill_mask;
    end

    assign stage[i+1] = amount[i] ? moved : stage[i];
  end

  assign shifted = (kind == SH_NONE) ? value : stage[STAGES];

endmodule

// File: rtl/agu_addr_calc.sv
module agu_addr_calc
  import agu_pkg::*;
#(
  parameter int unsigned W        = 32,
  parameter int unsigned IMM_W    = 12,
  parameter int unsigned PC_AHEAD = 8
) (
  input  addr_mode_e     mode,
  input  logic [W-1:0]   base,
  input  logic [W-1:0]   pc,
  input  logic [IMM_W-1:0] imm,
  input  logic           use_reg,
  input  logic           sub,
  input  logic [W-1:0]   reg_disp,
  output logic [W-1:0]   ea,
  output logic [W-1:0]   wb_data,
  output logic           wb_en
);

  localparam logic [W-1:0] AHEAD = W'(PC_AHEAD);

  logic [W-1:0] disp;
  logic [W-1:0] anchor;
  logic [W-1:0] moved;

  // PC-relative forms only take the immediate
  assign disp   = (use_reg && mode != AM_PC_REL) ? reg_disp : W'(imm);
  assign anchor = (mode == AM_PC_REL) ? (pc + AHEAD) : base;
  assign moved  = sub ? (anchor - disp) : (anchor + disp);

  always_comb begin
    ea      = moved;
    wb_data = moved;
    wb_en   = 1'b0;
    unique case (mode)
      AM_PRE:    wb_en = 1'b0;
      AM_PRE_WB: wb_en = 1'b1;
      AM_POST: begin
        ea    = base;
        wb_en = 1'b1;
      end
      AM_PC_REL: wb_en = 1'b0;
      default:   wb_en = 1'b0;
    endcase
  end

endmodule

// File: rtl/agu_out_stage.sv
module agu_out_stage #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         up_valid,
  output logic         up_ready,
  input  logic [W-1:0] d_ea,
  input  logic [W-1:0] d_wb,
  input  logic         d_wb_en,
  output logic         dn_valid,
  input  logic         dn_ready,
  output logic [W-1:0] q_ea,
  output logic [W-1:0] q_wb,
  output logic         q_wb_en
);

  logic take;

  assign up_ready = !dn_valid || dn_ready;
  assign take     = up_valid && up_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dn_valid <= 1'b0;
      q_ea     <= '0;
      q_wb     <= '0;
      q_wb_en  <= 1'b0;
    end else begin
      if (take) begin
        dn_valid <= 1'b1;
        q_ea     <= d_ea;
        q_wb     <= d_wb;
        q_wb_en  <= d_wb_en;
      end else if (dn_ready) begin
        dn_valid <= 1'b0;
      end
    end
  end

  p_stall_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    dn_valid && !dn_ready |=> dn_valid && $stable(q_ea) && $stable(q_wb) && $stable(q_wb_en));

  p_accept_shows_r8: assert property (@(posedge clk) disable iff (!rst_n)
    up_valid && up_ready |=> dn_valid);

  p_drain_r8: assert property (@(posedge clk) disable iff (!rst_n)
    dn_valid && dn_ready && !up_valid |=> !dn_valid);

  p_empty_ready_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !dn_valid |-> up_ready);

endmodule

// File: rtl/agu_ea_gen.sv
module agu_ea_gen
  import agu_pkg::*;
#(
  parameter int unsigned ADDR_W   = 32,
  parameter int unsigned IMM_W    = 12,
  parameter int unsigned SHAMT_W  = 5,
  parameter int unsigned PC_AHEAD = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic [1:0]         in_mode,
  input  logic [ADDR_W-1:0]  in_base,
  input  logic [ADDR_W-1:0]  in_pc,
  input  logic [IMM_W-1:0]   in_imm,
  input  logic               in_use_reg,
  input  logic               in_sub,
  input  logic [ADDR_W-1:0]  in_roff,
  input  logic [1:0]         in_shkind,
  input  logic [SHAMT_W-1:0] in_shamt,
  output logic               out_valid,
  input  logic               out_ready,
  output logic [ADDR_W-1:0]  out_ea,
  output logic [ADDR_W-1:0]  out_wb_data,
  output logic               out_wb_en
);

  addr_mode_e        mode;
  shift_kind_e       kind;
  logic [ADDR_W-1:0] reg_disp;
  logic [ADDR_W-1:0] calc_ea;
  logic [ADDR_W-1:0] calc_wb;
  logic              calc_wb_en;

  assign mode = addr_mode_e'(in_mode);
  assign kind = shift_kind_e'(in_shkind);

  agu_offset_shift #(
    .W       (ADDR_W),
    .SHAMT_W (SHAMT_W)
  ) u_shift (
    .value   (in_roff),
    .kind    (kind),
    .amount  (in_shamt),
    .shifted (reg_disp)
  );

  agu_addr_calc #(
    .W        (ADDR_W),
    .IMM_W    (IMM_W),
    .PC_AHEAD (PC_AHEAD)
  ) u_calc (
    .mode     (mode),
    .base     (in_base),
    .pc       (in_pc),
    .imm      (in_imm),
    .use_reg  (in_use_reg),
    .sub      (in_sub),
    .reg_disp (reg_disp),
    .ea       (calc_ea),
    .wb_data  (calc_wb),
    .wb_en    (calc_wb_en)
  );

  p_pre_no_wb_r1: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && mode == AM_PRE |-> !calc_wb_en && calc_wb == calc_ea);

  p_prewb_same_r2: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && mode == AM_PRE_WB |-> calc_wb_en && calc_wb == calc_ea);

  p_post_base_r3: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && mode == AM_POST |-> calc_wb_en && calc_ea == in_base);

  p_pcrel_no_wb_r4: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && mode == AM_PC_REL |-> !calc_wb_en);

  agu_out_stage #(
    .W (ADDR_W)
  ) u_stage (
    .clk      (clk),
    .rst_n    (rst_n),
    .up_valid (in_valid),
    .up_ready (in_ready),
    .d_ea     (calc_ea),
    .d_wb     (calc_wb),
    .d_wb_en  (calc_wb_en),
    .dn_valid (out_valid),
    .dn_ready (out_ready),
    .q_ea     (out_ea),
    .q_wb     (out_wb_data),
    .q_wb_en  (out_wb_en)
  );

endmodule

// File: tb/agu_ea_gen_tb.sv
module agu_ea_gen_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [1:0]  in_mode = 2'd0;
  logic [31:0] in_base = '0;
  logic [31:0] in_pc = '0;
  logic [11:0] in_imm = '0;
  logic        in_use_reg = 1'b0;
  logic        in_sub = 1'b0;
  logic [31:0] in_roff = '0;
  logic [1:0]  in_shkind = 2'd0;
  logic [4:0]  in_shamt = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [31:0] out_ea;
  logic [31:0] out_wb_data;
  logic        out_wb_en;

  always #5 clk = ~clk;

  agu_ea_gen u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_mode(in_mode), .in_base(in_base), .in_pc(in_pc), .in_imm(in_imm),
    .in_use_reg(in_use_reg), .in_sub(in_sub), .in_roff(in_roff),
    .in_shkind(in_shkind), .in_shamt(in_shamt), .out_valid(out_valid),
    .out_ready(out_ready), .out_ea(out_ea), .out_wb_data(out_wb_data),
    .out_wb_en(out_wb_en)
  );

  typedef struct {
    logic [31:0] ea;
    logic [31:0] wb;
    logic        en;
    string       tag;
  } exp_t;

  exp_t exp_q[$];
  int   checks = 0;
  int   errors = 0;
  bit   bp_on = 1'b0;
  bit   done = 1'b0;

  task automatic check(input bit ok, input string tag, input string msg);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: %s", tag, msg);
    end
  endtask

  function automatic exp_t model(input logic [1:0] mode, input logic [31:0] base,
                                 input logic [31:0] pc, input logic [11:0] imm,
                                 input logic use_reg, input logic sub,
                                 input logic [31:0] roff, input logic [1:0] sk,
                                 input logic [4:0] sa, input string tag);
    exp_t e;
    logic [31:0] mag, start, sum;
    if (use_reg && mode != 2'd3) begin
      case (sk)
        2'd0: mag = roff << sa;
        2'd1: mag = roff >> sa;
        2'd2: mag = 32'($signed(roff) >>> sa);
        default: mag = roff;
      endcase
    end else mag = {20'd0, imm};
    start = (mode == 2'd3) ? pc + 32'd8 : base;
    sum   = sub ? start - mag : start + mag;
    e.tag = tag;
    case (mode)
      2'd0: begin e.ea = sum;  e.wb = sum; e.en = 1'b0; end
      2'd1: begin e.ea = sum;  e.wb = sum; e.en = 1'b1; end
      2'd2: begin e.ea = base; e.wb = sum; e.en = 1'b1; end
      default: begin e.ea = sum; e.wb = sum; e.en = 1'b0; end
    endcase
    return e;
  endfunction

  task automatic send(input logic [1:0] mode, input logic [31:0] base,
                      input logic [31:0] pc, input logic [11:0] imm,
                      input logic use_reg, input logic sub, input logic [31:0] roff,
                      input logic [1:0] sk, input logic [4:0] sa, input string tag);
    bit acc = 1'b0;
    in_valid = 1'b1; in_mode = mode; in_base = base; in_pc = pc; in_imm = imm;
    in_use_reg = use_reg; in_sub = sub; in_roff = roff; in_shkind = sk; in_shamt = sa;
    while (!acc) begin
      @(negedge clk);
      if (in_ready) begin
        acc = 1'b1;
        exp_q.push_back(model(mode, base, pc, imm, use_reg, sub, roff, sk, sa, tag));
      end
      @(posedge clk); #1;
    end
    in_valid = 1'b0;
  endtask

  // consumer side back-pressure
  initial begin
    forever begin
      @(posedge clk); #1;
      out_ready = bp_on ? ($urandom_range(3) != 0) : 1'b1;
    end
  end

  // monitor / scoreboard
  initial begin
    bit prev_stall = 1'b0;
    logic [31:0] p_ea, p_wb;
    logic p_en;
    exp_t e;
    @(posedge rst_n);
    forever begin
      @(negedge clk);
      check(in_ready == (!out_valid || out_ready), "R9",
            $sformatf("in_ready=%0b expected %0b", in_ready, !out_valid || out_ready));
      if (prev_stall)
        check(out_valid && out_ea == p_ea && out_wb_data == p_wb && out_wb_en == p_en, "R8",
              $sformatf("held ea=%h wb=%h en=%0b expected ea=%h wb=%h en=%0b",
                        out_ea, out_wb_data, out_wb_en, p_ea, p_wb, p_en));
      if (out_valid && out_ready) begin
        if (exp_q.size() == 0) check(1'b0, "R8", "result with no pending request, expected none");
        else begin
          e = exp_q.pop_front();
          check(out_ea == e.ea && out_wb_data == e.wb && out_wb_en == e.en, e.tag,
                $sformatf("ea=%h wb=%h en=%0b expected ea=%h wb=%h en=%0b",
                          out_ea, out_wb_data, out_wb_en, e.ea, e.wb, e.en));
        end
      end
      prev_stall = out_valid && !out_ready;
      p_ea = out_ea; p_wb = out_wb_data; p_en = out_wb_en;
    end
  end

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  // watchdog
  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      check(1'b0, "WDOG", "run hung, expected completion");
      finish_run();
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    @(negedge clk);
    check(!out_valid && in_ready, "R10",
          $sformatf("in reset valid=%0b ready=%0b expected 0/1", out_valid, in_ready));
    @(posedge clk); #1 rst_n = 1'b1;
    @(negedge clk);
    check(!out_valid && in_ready, "R10",
          $sformatf("after reset valid=%0b ready=%0b expected 0/1", out_valid, in_ready));
    @(posedge clk); #1;

    // directed cases
    send(2'd0, 32'd1000, 0, 12'd200, 0, 0, 0, 0, 0, "R1");
    send(2'd0, 32'd1000, 0, 12'd4095, 0, 1, 0, 0, 0, "R1");
    send(2'd0, 32'd5000, 0, 12'd0, 0, 1, 0, 0, 0, "R5");
    send(2'd1, 32'd1000, 0, 0, 1, 0, 32'd200, 2'd0, 5'd0, "R2");
    send(2'd1, 32'd4000, 0, 0, 1, 1, 32'd3, 2'd0, 5'd4, "R2");
    send(2'd2, 32'd1000, 0, 0, 1, 0, 32'd200, 2'd3, 5'd9, "R3");
    send(2'd2, 32'd1000, 0, 12'd4095, 0, 1, 0, 0, 0, "R3");
    send(2'd3, 32'd77, 32'd1000, 12'd52, 0, 0, 0, 0, 0, "R4");
    send(2'd3, 32'd77, 32'd8000, 12'd4095, 1, 1, 32'hFFFF, 2'd0, 5'd3, "R4");
    send(2'd0, 32'd0, 0, 0, 1, 0, 32'h8000_0000, 2'd1, 5'd0, "R6");
    send(2'd0, 32'd0, 0, 0, 1, 0, 32'h8000_0000, 2'd1, 5'd31, "R6");
    send(2'd0, 32'd0, 0, 0, 1, 0, 32'hF000_0000, 2'd2, 5'd4, "R6");
    send(2'd0, 32'd0, 0, 0, 1, 0, 32'h8000_0000, 2'd2, 5'd31, "R6");
    send(2'd0, 32'd0, 0, 0, 1, 0, 32'h8123_4567, 2'd2, 5'd0, "R6");
    send(2'd0, 32'd0, 0, 0, 1, 0, 32'h0000_0001, 2'd0, 5'd31, "R6");
    send(2'd0, 32'hFFFF_FFF0, 0, 12'h020, 0, 0, 0, 0, 0, "R7");
    send(2'd2, 32'd4, 0, 12'd8, 0, 1, 0, 0, 0, "R7");
    send(2'd3, 32'd0, 32'hFFFF_FFFC, 12'd4, 0, 0, 0, 0, 0, "R7");

    // random traffic under back-pressure
    bp_on = 1'b1;
    for (int i = 0; i < 300; i++) begin
      send(2'($urandom_range(3)), $urandom, $urandom, 12'($urandom), 1'($urandom),
           1'($urandom), $urandom, 2'($urandom_range(3)), 5'($urandom), "R8");
    end
    bp_on = 1'b0;
    repeat (10) @(posedge clk);
    #1;
    check(exp_q.size() == 0, "R8", $sformatf("pending=%0d expected 0", exp_q.size()));
    done = 1'b1;
    finish_run();
  end

endmodule